// File: doc/BRIEF.md
# DMA channel control register bank

This block holds the software-visible state of a single DMA channel. It has four 32-bit words behind a simple register bus: a control/status word, a current memory address, a byte count and an upper-address base. The control word carries an interrupt enable and an interrupt-pending flag. The pending flag follows a level request coming from the attached peripheral. The CPU interrupt line is driven high only while both the flag and the enable are set.

Software uses the control word for several jobs. It can send a one-cycle reset pulse to the peripheral. It sets the transfer direction. It also touches a drain flag, which has write rules of its own. Some fields of the control word cannot be changed by software, and the top nibble always reads back as a fixed version number. Writing the address word also sets a "loaded" status bit in the control word. The transfer engine, which is outside this block, sends a done strobe together with a byte length, and the address word advances by that length.

Top module: `dma_regbank`

## Requirements
- R1: After reset the control word reads 0xA0000000 and the address, count and base words read 0. Both `irq` and `periph_rst` are low.
- R2: The word is selected by offset bits [3:2] only: 0 is control, 1 is address, 2 is count and 3 is base. All other offset bits are ignored, so offset 0x14 reaches the address word. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R3: A control write keeps the old values of bits [31:25] and [2:0] and replaces all other bits with the written ones. Bits [31:28] always read 0xA. Writing all ones gives 0xA1FFFFF8 when the protected bits hold 0xA0000000.
- R4: When written bit 7 is 0, the drain bit (bit 6) has special rules. A written 1 in bit 6 is stored as 0. A write of all zeros stores bit 6 as 1. When written bit 7 is 1, bit 6 is stored as written.
- R5: A control write with bit 7 set drives `periph_rst` high for exactly the next cycle. Bit 7 is stored as written.
- R6: A write to the address word sets control bit 26 (loaded). Because this bit is protected, a later control write does not clear it.
- R7: A rising edge on `periph_req` sets control bit 0 (pending). The new value is visible in the cycle after the edge.
- R8: A falling edge on `periph_req` clears control bit 0.
- R9: `irq` is high exactly when pending (bit 0) and enable (bit 4) are both set. It changes in the cycle after the request edge or control write that alters either bit.
- R10: A `xfer_done` strobe adds `xfer_len` to the address word. If an address write happens in the same cycle, the written value wins.
- R11: The count and base words store and return the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFS_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| periph_req | input | 1 | Level interrupt request from the peripheral |
| xfer_done | input | 1 | One-cycle strobe from the transfer engine |
| xfer_len | input | LEN_W | Bytes moved by the finished transfer |
| irq | output | 1 | Interrupt line to the CPU |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
The bench writes all ones and then all zeros to the control word, and checks that the protected bits, the version nibble and the loaded flag survive both writes. A design that applied the merge mask the wrong way round would lose the version number or clear the loaded flag. The three drain cases (drain written as 1, an all-zero write, and a write with the reset bit set) are each checked on their own, which catches an inverted or misordered rule.

The interrupt checks cover a request that rises while the enable is off and is then enabled later, and also disabling the enable while the request is still pending. Other cases are an address write that arrives in the same cycle as a done strobe, and an access at an offset above 0x10. A design that only drove the line on a request edge would miss the late enable. Full offset decoding would send the high-offset access to the wrong word.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int OFS_W = 8,
  parameter int LEN_W = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             periph_req,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             irq,
  output logic             periph_rst
);
  localparam logic [31:0] RO_MASK  = 32'hFE00_0007;
  localparam logic [31:0] VER_BITS = {VERSION, 28'h0};

  logic [31:0] ctrl_q, addr_q, cnt_q, base_q;
  logic [31:0] ctrl_d, wval, rmux;
  logic        req_q, rst_q;

  wire [1:0] idx     = bus_addr[3:2];
  wire       wr_en   = bus_sel & bus_wr;
  wire       rd_en   = bus_sel & ~bus_wr;
  wire       ctrl_wr = wr_en && idx == 2'd0;
  wire       addr_wr = wr_en && idx == 2'd1;
  wire       cnt_wr  = wr_en && idx == 2'd2;
  wire       base_wr = wr_en && idx == 2'd3;
  wire       req_rise = periph_req & ~req_q;
  wire       req_fall = ~periph_req & req_q;
  wire       unused_ofs = ^{bus_addr[OFS_W-1:4], bus_addr[1:0]};

  always_comb begin
    wval = bus_wdata;
    if (!bus_wdata[7]) begin
      if (bus_wdata[6])          wval[6] = 1'b0;
      else if (bus_wdata == '0)  wval[6] = 1'b1;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = (ctrl_q & RO_MASK) | (wval & ~RO_MASK) | VER_BITS;
    if (addr_wr) ctrl_d[26] = 1'b1;
    if (req_rise)      ctrl_d[0] = 1'b1;
    else if (req_fall) ctrl_d[0] = 1'b0;
  end

  always_comb begin
    case (idx)
      2'd0:    rmux = ctrl_q;
      2'd1:    rmux = addr_q;
      2'd2:    rmux = cnt_q;
      default: rmux = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= VER_BITS;
      addr_q    <= '0;
      cnt_q     <= '0;
      base_q    <= '0;
      req_q     <= 1'b0;
      rst_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      req_q  <= periph_req;
      rst_q  <= ctrl_wr & bus_wdata[7];
      if (rd_en) bus_rdata <= rmux;
      if (addr_wr)        addr_q <= bus_wdata;
      else if (xfer_done) addr_q <= addr_q + {{(32-LEN_W){1'b0}}, xfer_len};
      if (cnt_wr)  cnt_q  <= bus_wdata;
      if (base_wr) base_q <= bus_wdata;
    end
  end

  assign irq        = ctrl_q[0] & ctrl_q[4];
  assign periph_rst = rst_q;
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int OFS_W = 8,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [OFS_W-1:0] bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             periph_req,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             irq,
  input logic             periph_rst,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      addr_q,
  input logic             req_q
);
  wire ctrl_w = bus_sel && bus_wr && bus_addr[3:2] == 2'd0;
  wire addr_w = bus_sel && bus_wr && bus_addr[3:2] == 2'd1;

  // R3
  version_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31:28] == 4'hA);

  // R5
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && bus_wdata[7] |=> periph_rst);

  // R5
  rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst) |-> $past(ctrl_w && bus_wdata[7]));

  // R6
  loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_w |=> ctrl_q[26]);

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_req && !req_q |=> ctrl_q[0]);

  // R8
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_req && req_q |=> !ctrl_q[0]);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(periph_req || (ctrl_w && bus_wdata[4])));

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !addr_w |=> addr_q == $past(addr_q + {{(32-LEN_W){1'b0}}, xfer_len}));
endmodule

bind dma_regbank dma_regbank_chk #(.OFS_W(OFS_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .periph_req(periph_req),
  .xfer_done(xfer_done), .xfer_len(xfer_len), .irq(irq),
  .periph_rst(periph_rst), .ctrl_q(ctrl_q), .addr_q(addr_q), .req_q(req_q)
);

// File: tb/dma_regbank_test.sv
`timescale 1ns/1ps
module dma_regbank_test;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, req = 0, done = 0;
  logic [7:0]  ofs = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] len = 0;
  logic irq, prst;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(ofs),
    .bus_wdata(wdata), .bus_rdata(rdata), .periph_req(req),
    .xfer_done(done), .xfer_len(len), .irq(irq), .periph_rst(prst)
  );

  // behavioural reference
  logic [31:0] m_reg [4];
  logic [31:0] m_rd;
  logic m_prev, m_irq, m_prst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_rd = 0; m_prev = 0; m_irq = 0; m_prst = 0;
    end else begin
      automatic int k = int'(ofs[3:2]);
      automatic logic [31:0] v = wdata;
      m_prst = sel && wr && k == 0 && wdata[7];
      if (sel && !wr) m_rd = m_reg[k];
      if (sel && wr) begin
        if (k == 0) begin
          if (!v[7] && v[6]) v[6] = 0;
          else if (!v[7] && v == 0) v[6] = 1;
          m_reg[0] = {4'hA, m_reg[0][27:25], v[24:3], m_reg[0][2:0]};
          if (v[4]) begin if (m_reg[0][0]) m_irq = 1; end
          else m_irq = 0;
        end else begin
          m_reg[k] = wdata;
          if (k == 1) m_reg[0][26] = 1;
        end
      end
      if (done && !(sel && wr && k == 1)) m_reg[1] = m_reg[1] + 32'(len);
      if (req && !m_prev) begin
        m_reg[0][0] = 1;
        if (m_reg[0][4]) m_irq = 1;
      end else if (!req && m_prev) begin
        if (m_reg[0][0] && m_reg[0][4]) m_irq = 0;
        m_reg[0][0] = 0;
      end
      m_prev = req;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 model rdata", rdata, m_rd);
    chk("R9 model irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R5 model periph_rst", {31'b0, prst}, {31'b0, m_prst});
  end

  task automatic wr_reg(logic [7:0] o, logic [31:0] d);
    sel = 1; wr = 1; ofs = o; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] o, output logic [31:0] v);
    sel = 1; wr = 0; ofs = o;
    @(negedge clk);
    v = rdata; sel = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd_reg(8'h00, v); chk("R1 ctrl", v, 32'hA000_0000);
    rd_reg(8'h04, v); chk("R1 addr", v, 0);
    rd_reg(8'h08, v); chk("R1 count", v, 0);
    rd_reg(8'h0C, v); chk("R1 base", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 periph_rst", {31'b0, prst}, 0);
    // R3 / R5
    wr_reg(8'h00, 32'hFFFF_FFFF);
    chk("R5 pulse high", {31'b0, prst}, 1);
    @(negedge clk);
    chk("R5 pulse low", {31'b0, prst}, 0);
    rd_reg(8'h00, v); chk("R3 all ones", v, 32'hA1FF_FFF8);
    // R4
    wr_reg(8'h00, 0);          rd_reg(8'h00, v); chk("R4 zero write", v, 32'hA000_0040);
    wr_reg(8'h00, 32'h40);     rd_reg(8'h00, v); chk("R4 drain one", v, 32'hA000_0000);
    wr_reg(8'h00, 32'h50);     rd_reg(8'h00, v); chk("R4 drain with enable", v, 32'hA000_0010);
    // R6
    wr_reg(8'h04, 32'h1000);   rd_reg(8'h00, v); chk("R6 loaded", v, 32'hA400_0010);
    wr_reg(8'h00, 0);          rd_reg(8'h00, v); chk("R6 R3 zero keeps ro", v, 32'hA400_0040);
    // R2 / R11
    rd_reg(8'h14, v); chk("R2 alias offset", v, 32'h1000);
    wr_reg(8'h18, 32'hDEAD_BEEF); rd_reg(8'h08, v); chk("R11 count", v, 32'hDEAD_BEEF);
    wr_reg(8'h0C, 32'h1234_5678); rd_reg(8'h3C, v); chk("R11 base", v, 32'h1234_5678);
    // R10
    done = 1; len = 16'h20; @(negedge clk); done = 0;
    rd_reg(8'h04, v); chk("R10 advance", v, 32'h1020);
    done = 1; len = 16'h4; wr_reg(8'h04, 32'h2000); done = 0;
    rd_reg(8'h04, v); chk("R10 write wins", v, 32'h2000);
    // R7 / R8 / R9
    wr_reg(8'h00, 32'h10);
    req = 1; @(negedge clk);
    chk("R9 raise", {31'b0, irq}, 1);
    rd_reg(8'h00, v); chk("R7 pending", v, 32'hA400_0011);
    req = 0; @(negedge clk);
    chk("R9 lower", {31'b0, irq}, 0);
    rd_reg(8'h00, v); chk("R8 cleared", v, 32'hA400_0010);
    wr_reg(8'h00, 0);
    req = 1; @(negedge clk);
    chk("R9 masked", {31'b0, irq}, 0);
    wr_reg(8'h00, 32'h10); chk("R9 late enable", {31'b0, irq}, 1);
    wr_reg(8'h00, 32'h40); chk("R9 disable", {31'b0, irq}, 0);
    rd_reg(8'h00, v); chk("R7 R4 pending kept", v, 32'hA400_0001);
    req = 0; @(negedge clk);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      sel = $urandom_range(0, 1); wr = $urandom_range(0, 1);
      ofs = 8'($urandom);
      case ($urandom_range(0, 3))
        0: wdata = 0;
        1: wdata = 32'hFFFF_FFFF;
        2: wdata = {24'($urandom), 1'b0, 1'($urandom), 1'b1, 5'($urandom)};
        default: wdata = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) req = ~req;
      done = ($urandom_range(0, 3) == 0);
      len = 16'($urandom);
      @(negedge clk);
    end
    sel = 0; done = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule